// File: doc/BRIEF.md
# Multi-Panel Flash Write Stager

This block stages bytes for a code-memory array that is divided into panels and then writes them into the array in one step. Every panel owns a small write buffer. Bytes arrive one at a time on a load port whose address carries a row offset, a panel index and a byte index. A later commit request programs the buffered bytes into a synchronous memory model. In multi-panel mode every panel is written in the same cycle, at one shared row offset. In single-panel mode only the panel named by the commit pointer is written.

The commit pointer's row must match the row that was captured by the most recent load. If it does not, the commit is refused with a one-cycle error pulse and nothing changes. A single control bit selects the mode. That bit sits behind a fixed configuration address. A registered read port gives access to the array contents.

Top module: `mpw_flash_stager`

## Requirements
- R1: After reset, every array byte reads 0xFF, every write buffer holds 0xFF, `cm_done` and `cm_err` are low, and multi-panel mode is selected.
- R2: A load (`ld_valid` high, `cm_req` low) stores `ld_data` in the buffer of panel `ld_addr[5:3]` at byte `ld_addr[2:0]`. The row field is `ld_addr[9:6]`.
- R3: An accepted commit in multi-panel mode writes all 8 panel buffers, 64 bytes, into row `cm_ptr[6:3]` of every panel in the same clock edge.
- R4: An accepted commit in single-panel mode writes only the buffer of panel `cm_ptr[2:0]`. The array contents of every other panel stay unchanged.
- R5: A commit whose row `cm_ptr[6:3]` differs from the captured row gives `cm_err` high for exactly the next cycle. It leaves the array unchanged, leaves all buffers unchanged, and does not pulse `cm_done`.
- R6: An accepted commit gives `cm_done` high for exactly the cycle after the request. Every buffer it wrote returns to 0xFF.
- R7: In single-panel mode, the buffers of panels not selected by the commit keep their contents for later commits.
- R8: The mode bit is written with `cfg_wbit` (1 = multi-panel, 0 = single-panel) only when `cfg_wr` is high and `cfg_addr` equals 0x3C0006. Writes to any other address have no effect.
- R9: `rd_data` shows the byte at `rd_addr` (same field layout as `ld_addr`) one clock edge after the address is presented.
- R10: A load in a cycle where `cm_req` is high is dropped. It changes neither a buffer nor the captured row.
- R11: The captured row is the row field of the most recent accepted load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 22 | Configuration write address |
| cfg_wbit | input | 1 | New value of the multi-panel enable bit |
| ld_valid | input | 1 | Byte load strobe |
| ld_addr | input | 10 | Load address {row, panel, byte} |
| ld_data | input | 8 | Byte to load |
| cm_req | input | 1 | Commit request |
| cm_ptr | input | 7 | Commit pointer {row, panel} |
| rd_addr | input | 10 | Array read address {row, panel, byte} |
| rd_data | output | 8 | Registered array read data |
| cm_done | output | 1 | One-cycle pulse after an accepted commit |
| cm_err | output | 1 | One-cycle pulse after a refused commit |

## Verification
Buffers and the captured row are hidden, so a wrong value there only shows up at a later commit. It appears as a wrong byte one read after that commit, or as a wrong `cm_done`/`cm_err` pulse in the cycle after the request. The stimulus therefore leaves bytes in unselected buffers on purpose and commits them later. It also issues refused commits and then accepted ones, and commits buffers that were already cleared. A corrupted buffer, row or mode state then surfaces within two cycles of the next commit.

// File: rtl/mpw_pkg.sv
package mpw_pkg;

  localparam int unsigned BYTE_BITS = 8;

  typedef logic [BYTE_BITS-1:0] mpw_byte_t;

  // value of an erased or empty byte
  localparam mpw_byte_t ERASED_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    CM_NONE,
    CM_WRITE,
    CM_REFUSE
  } cm_action_e;

endpackage

// File: rtl/mpw_mode_reg.sv
module mpw_mode_reg #(
  parameter int unsigned        ADDR_W      = 22,
  parameter logic [ADDR_W-1:0]  CTRL_ADDR   = 22'h3C0006,
  parameter logic               RESET_MULTI = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wbit,
  output logic              multi_q
);

  logic mode_q;
  logic mode_d;
  logic mode_en;

  always_comb begin
    mode_en = cfg_wr && (cfg_addr == CTRL_ADDR);
    mode_d  = cfg_wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RESET_MULTI;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign multi_q = mode_q;

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && (cfg_addr == CTRL_ADDR)) |=> $stable(mode_q));

endmodule

// File: rtl/mpw_panel_buf.sv
module mpw_panel_buf import mpw_pkg::*; #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned IDX_W  = $clog2(DEPTH),
  parameter int unsigned LINE_W = DEPTH * BYTE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  mpw_byte_t        wr_data,
  input  logic             clr,
  output logic [LINE_W-1:0] line_q
);

  for (genvar b = 0; b < DEPTH; b++) begin : g_byte
    mpw_byte_t byte_q;
    mpw_byte_t byte_d;
    logic      byte_en;

    always_comb begin
      byte_en = clr || (wr_en && (wr_idx == IDX_W'(b)));
      byte_d  = clr ? ERASED_BYTE : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= ERASED_BYTE;
      end else if (byte_en) begin
        byte_q <= byte_d;
      end
    end

    assign line_q[b*BYTE_BITS +: BYTE_BITS] = byte_q;
  end

  // R10: the controller never loads a buffer it is clearing
  wr_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && clr));

  // R6
  clr_erased_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (line_q == {DEPTH{ERASED_BYTE}}));

endmodule

// File: rtl/mpw_panel_mem.sv
module mpw_panel_mem import mpw_pkg::*; #(
  parameter int unsigned ROWS   = 16,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ROW_W  = $clog2(ROWS),
  parameter int unsigned IDX_W  = $clog2(DEPTH),
  parameter int unsigned LINE_W = DEPTH * BYTE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [IDX_W-1:0]  rd_idx,
  output mpw_byte_t         rd_q
);

  localparam logic [LINE_W-1:0] ERASED_LINE = {DEPTH{ERASED_BYTE}};

  logic [LINE_W-1:0] line_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic row_en;

    always_comb begin
      row_en = wr_en && (wr_row == ROW_W'(r));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q[r] <= ERASED_LINE;
      end else if (row_en) begin
        line_q[r] <= wr_line;
      end
    end
  end

  logic [LINE_W-1:0] rd_line;
  mpw_byte_t         rd_d;

  always_comb begin
    rd_line = line_q[rd_row];
    rd_d    = rd_line[rd_idx*BYTE_BITS +: BYTE_BITS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= ERASED_BYTE;
    end else begin
      rd_q <= rd_d;
    end
  end

  // R3
  row_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (line_q[$past(wr_row)] == $past(wr_line)));

endmodule

// File: rtl/mpw_flash_stager.sv
module mpw_flash_stager import mpw_pkg::*; #(
  parameter int unsigned           NUM_PANELS = 8,
  parameter int unsigned           BUF_DEPTH  = 8,
  parameter int unsigned           PANEL_ROWS = 16,
  parameter int unsigned           CFG_ADDR_W = 22,
  parameter logic [CFG_ADDR_W-1:0] CTRL_ADDR  = 22'h3C0006,
  parameter int unsigned           IDX_W      = $clog2(BUF_DEPTH),
  parameter int unsigned           PAN_W      = $clog2(NUM_PANELS),
  parameter int unsigned           ROW_W      = $clog2(PANEL_ROWS),
  parameter int unsigned           ARR_W      = ROW_W + PAN_W + IDX_W,
  parameter int unsigned           PTR_W      = ROW_W + PAN_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic                  cfg_wbit,
  input  logic                  ld_valid,
  input  logic [ARR_W-1:0]      ld_addr,
  input  mpw_byte_t             ld_data,
  input  logic                  cm_req,
  input  logic [PTR_W-1:0]      cm_ptr,
  input  logic [ARR_W-1:0]      rd_addr,
  output mpw_byte_t             rd_data,
  output logic                  cm_done,
  output logic                  cm_err
);

  localparam int unsigned LINE_W = BUF_DEPTH * BYTE_BITS;

  // ---------------- address fields ----------------
  logic [IDX_W-1:0] ld_idx;
  logic [PAN_W-1:0] ld_pan;
  logic [ROW_W-1:0] ld_row;
  logic [PAN_W-1:0] cm_pan;
  logic [ROW_W-1:0] cm_row;
  logic [IDX_W-1:0] rd_idx;
  logic [PAN_W-1:0] rd_pan;
  logic [ROW_W-1:0] rd_row;

  always_comb begin
    ld_idx = ld_addr[IDX_W-1:0];
    ld_pan = ld_addr[IDX_W +: PAN_W];
    ld_row = ld_addr[IDX_W+PAN_W +: ROW_W];
    cm_pan = cm_ptr[PAN_W-1:0];
    cm_row = cm_ptr[PAN_W +: ROW_W];
    rd_idx = rd_addr[IDX_W-1:0];
    rd_pan = rd_addr[IDX_W +: PAN_W];
    rd_row = rd_addr[IDX_W+PAN_W +: ROW_W];
  end

  // ---------------- mode register ----------------
  logic multi_mode;

  mpw_mode_reg #(
    .ADDR_W      (CFG_ADDR_W),
    .CTRL_ADDR   (CTRL_ADDR),
    .RESET_MULTI (1'b1)
  ) i_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .cfg_wbit (cfg_wbit),
    .multi_q  (multi_mode)
  );

  // ---------------- captured row ----------------
  logic             ld_take;
  logic [ROW_W-1:0] lat_row_q;
  logic [ROW_W-1:0] lat_row_d;

  always_comb begin
    ld_take   = ld_valid && !cm_req;
    lat_row_d = ld_row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_row_q <= '0;
    end else if (ld_take) begin
      lat_row_q <= lat_row_d;
    end
  end

  // ---------------- commit decision ----------------
  cm_action_e cm_act;

  always_comb begin
    cm_act = CM_NONE;
    if (cm_req) begin
      cm_act = (cm_row == lat_row_q) ? CM_WRITE : CM_REFUSE;
    end
  end

  logic done_d;
  logic err_d;
  logic done_q;
  logic err_q;

  always_comb begin
    done_d = (cm_act == CM_WRITE);
    err_d  = (cm_act == CM_REFUSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign cm_done = done_q;
  assign cm_err  = err_q;

  // ---------------- panels ----------------
  logic [NUM_PANELS-1:0] pan_commit;
  mpw_byte_t             pan_rd_q [NUM_PANELS];

  for (genvar p = 0; p < NUM_PANELS; p++) begin : g_panel
    logic              sel;
    logic              buf_we;
    logic [LINE_W-1:0] buf_line;

    always_comb begin
      sel           = multi_mode || (cm_pan == PAN_W'(p));
      pan_commit[p] = (cm_act == CM_WRITE) && sel;
      buf_we        = ld_take && (ld_pan == PAN_W'(p));
    end

    mpw_panel_buf #(
      .DEPTH (BUF_DEPTH)
    ) i_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (buf_we),
      .wr_idx  (ld_idx),
      .wr_data (ld_data),
      .clr     (pan_commit[p]),
      .line_q  (buf_line)
    );

    mpw_panel_mem #(
      .ROWS  (PANEL_ROWS),
      .DEPTH (BUF_DEPTH)
    ) i_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (pan_commit[p]),
      .wr_row  (cm_row),
      .wr_line (buf_line),
      .rd_row  (rd_row),
      .rd_idx  (rd_idx),
      .rd_q    (pan_rd_q[p])
    );
  end

  // ---------------- read mux ----------------
  logic [PAN_W-1:0] rd_pan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pan_q <= '0;
    end else begin
      rd_pan_q <= rd_pan;
    end
  end

  assign rd_data = pan_rd_q[rd_pan_q];

  // ---------------- assertions ----------------
  // R5
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_req && (cm_row != lat_row_q)) |=> (cm_err && !cm_done));

  // R5
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cm_done && cm_err));

  // R6
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_done |-> $past(cm_req));

  // R3
  multi_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_req && multi_mode && (cm_row == lat_row_q)) |-> (&pan_commit));

  // R4
  single_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_req && !multi_mode) |-> ($countones(pan_commit) <= 1));

  // R11
  row_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !cm_req) |=> (lat_row_q == $past(ld_row)));

endmodule

// File: tb/test_mpw_flash_stager.sv
module test_mpw_flash_stager;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [7:0] OP_LD  = 8'd1;
  localparam logic [7:0] OP_CM  = 8'd2;
  localparam logic [7:0] OP_CFG = 8'd3;
  localparam logic [7:0] OP_RD  = 8'd4;
  localparam logic [7:0] X_DONE = 8'h01;
  localparam logic [7:0] X_ERR  = 8'h02;
  localparam logic [21:0] CTRL  = 22'h3C0006;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [21:0] cfg_addr;
  logic        cfg_wbit;
  logic        ld_valid;
  logic [9:0]  ld_addr;
  logic [7:0]  ld_data;
  logic        cm_req;
  logic [6:0]  cm_ptr;
  logic [9:0]  rd_addr;
  logic [7:0]  rd_data;
  logic        cm_done;
  logic        cm_err;

  int n_vec;
  int n_bad;

  mpw_flash_stager i_mpw_flash_stager (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .cfg_wbit (cfg_wbit),
    .ld_valid (ld_valid),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .cm_req   (cm_req),
    .cm_ptr   (cm_ptr),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .cm_done  (cm_done),
    .cm_err   (cm_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [21:0] A(input int row, input int pan, input int idx);
    return {12'b0, row[3:0], pan[2:0], idx[2:0]};
  endfunction

  function automatic logic [21:0] P(input int row, input int pan);
    return {15'b0, row[3:0], pan[2:0]};
  endfunction

  function automatic logic [55:0] mk(input logic [7:0] op, input int req,
                                     input logic [21:0] addr, input logic [7:0] data,
                                     input logic [7:0] exp);
    return {op, req[7:0], 2'b00, addr, data, exp};
  endfunction

  localparam int NV = 32;
  localparam logic [55:0] VECS [NV] = '{
    mk(OP_LD,  2, A(2,0,0), 8'h11, 8'h00),   // R2
    mk(OP_LD,  2, A(2,3,5), 8'h35, 8'h00),   // R2
    mk(OP_LD,  2, A(2,7,7), 8'h77, 8'h00),   // R2
    mk(OP_CM,  3, P(2,0),   8'h00, X_DONE),  // R3
    mk(OP_RD,  2, A(2,0,0), 8'h00, 8'h11),   // R2
    mk(OP_RD,  3, A(2,3,5), 8'h00, 8'h35),   // R3
    mk(OP_RD,  3, A(2,7,7), 8'h00, 8'h77),   // R3
    mk(OP_RD,  3, A(2,4,1), 8'h00, 8'hFF),   // R3
    mk(OP_LD, 11, A(5,1,2), 8'hA5, 8'h00),   // R11
    mk(OP_CM,  5, P(6,1),   8'h00, X_ERR),   // R5 row mismatch
    mk(OP_RD,  5, A(6,1,2), 8'h00, 8'hFF),   // R5 array unchanged
    mk(OP_CM,  5, P(5,0),   8'h00, X_DONE),  // R5 buffers kept
    mk(OP_RD,  5, A(5,1,2), 8'h00, 8'hA5),   // R5
    mk(OP_RD,  6, A(5,3,5), 8'h00, 8'hFF),   // R6 cleared by earlier commit
    mk(OP_CFG, 8, CTRL,     8'h00, 8'h00),   // R8 select single
    mk(OP_LD,  2, A(9,2,0), 8'h20, 8'h00),   // R2
    mk(OP_LD,  2, A(9,4,0), 8'h40, 8'h00),   // R2
    mk(OP_CM,  4, P(9,2),   8'h00, X_DONE),  // R4
    mk(OP_RD,  4, A(9,2,0), 8'h00, 8'h20),   // R4
    mk(OP_RD,  4, A(9,4,0), 8'h00, 8'hFF),   // R4 other panel untouched
    mk(OP_CM,  7, P(9,4),   8'h00, X_DONE),  // R7
    mk(OP_RD,  7, A(9,4,0), 8'h00, 8'h40),   // R7 retained buffer
    mk(OP_RD,  4, A(9,2,0), 8'h00, 8'h20),   // R4
    mk(OP_CFG, 8, CTRL + 22'd1, 8'h01, 8'h00), // R8 wrong address
    mk(OP_LD,  2, A(12,0,0), 8'hC0, 8'h00),  // R2
    mk(OP_LD,  2, A(12,1,0), 8'hC1, 8'h00),  // R2
    mk(OP_CM,  8, P(12,0),  8'h00, X_DONE),  // R8 still single
    mk(OP_RD,  8, A(12,1,0), 8'h00, 8'hFF),  // R8
    mk(OP_CFG, 8, CTRL,     8'h01, 8'h00),   // R8 select multi
    mk(OP_CM,  6, P(12,0),  8'h00, X_DONE),  // R6
    mk(OP_RD,  7, A(12,1,0), 8'h00, 8'hC1),  // R7
    mk(OP_RD,  6, A(12,0,0), 8'h00, 8'hFF)   // R6 buffer cleared
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic idle_inputs();
    cfg_wr   = 1'b0;
    cfg_addr = '0;
    cfg_wbit = 1'b0;
    ld_valid = 1'b0;
    ld_addr  = '0;
    ld_data  = '0;
    cm_req   = 1'b0;
    cm_ptr   = '0;
  endtask

  task automatic check_out(input int req, input logic [7:0] op, input logic [7:0] exp);
    logic xd;
    logic xe;
    logic ok;
    xd = (op == OP_CM) && (exp == X_DONE);
    xe = (op == OP_CM) && (exp == X_ERR);
    ok = (cm_done == xd) && (cm_err == xe) && ((op != OP_RD) || (rd_data == exp));
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d op=%0d: actual data=%h done=%b err=%b, expected data=%h done=%b err=%b",
               req, op, rd_data, cm_done, cm_err, (op == OP_RD) ? exp : rd_data, xd, xe);
    end
  endtask

  task automatic apply(input logic [7:0] op, input int req, input logic [21:0] addr,
                       input logic [7:0] data, input logic [7:0] exp);
    @(negedge clk);
    idle_inputs();
    case (op)
      OP_LD:  begin ld_valid = 1'b1; ld_addr = addr[9:0]; ld_data = data; end
      OP_CM:  begin cm_req = 1'b1; cm_ptr = addr[6:0]; end
      OP_CFG: begin cfg_wr = 1'b1; cfg_addr = addr; cfg_wbit = data[0]; end
      OP_RD:  begin rd_addr = addr[9:0]; end
      default: ;
    endcase
    @(posedge clk);
    #1;
    check_out(req, op, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    n_vec = 0;
    n_bad = 0;
    idle_inputs();
    rd_addr = '0;
    rst_n   = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of flags and array
    apply(OP_RD, 1, A(0,0,0), 8'h00, 8'hFF);
    apply(OP_RD, 1, A(15,7,7), 8'h00, 8'hFF);
    apply(OP_RD, 1, A(7,3,4), 8'h00, 8'hFF);
    // R1: committing untouched buffers in the reset mode writes 0xFF across all panels
    apply(OP_CM, 1, P(0,0), 8'h00, X_DONE);
    apply(OP_RD, 1, A(0,6,3), 8'h00, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i][55:48], int'(VECS[i][47:40]), VECS[i][37:16],
            VECS[i][15:8], VECS[i][7:0]);
    end

    // R10: load in the same cycle as a commit is dropped
    apply(OP_LD, 10, A(13,5,5), 8'h55, 8'h00);
    @(negedge clk);
    idle_inputs();
    ld_valid = 1'b1;
    ld_addr  = A(13,0,0);
    ld_data  = 8'hD0;
    cm_req   = 1'b1;
    cm_ptr   = P(13,0);
    @(posedge clk);
    #1;
    check_out(10, OP_CM, X_DONE);
    apply(OP_RD, 10, A(13,5,5), 8'h00, 8'h55);
    apply(OP_RD, 10, A(13,0,0), 8'h00, 8'hFF);
    // R10: dropped load also leaves the captured row at 13
    apply(OP_CM, 10, P(13,0), 8'h00, X_DONE);

    // R11: most recent load decides the captured row
    apply(OP_LD, 11, A(3,6,0), 8'h63, 8'h00);
    apply(OP_LD, 11, A(4,6,1), 8'h64, 8'h00);
    apply(OP_CM, 11, P(3,0), 8'h00, X_ERR);
    apply(OP_CM, 11, P(4,0), 8'h00, X_DONE);
    apply(OP_RD, 11, A(4,6,0), 8'h00, 8'h63);

    // R9: read data changes only after the clock edge
    @(negedge clk);
    idle_inputs();
    rd_addr = A(4,6,1);
    #1;
    n_vec++;
    if (rd_data != 8'h63) begin
      n_bad++;
      $display("FAIL R9 before edge: actual data=%h expected data=%h", rd_data, 8'h63);
    end
    @(posedge clk);
    #1;
    check_out(9, OP_RD, 8'h64);

    @(negedge clk);
    idle_inputs();
    summary();
    $finish;
  end

endmodule